// File: doc/BRIEF.md
# Register-Mapped SPI Master with Receive-Level Interrupt

This block is a serial peripheral interface master that a processor drives through a small 32-bit register window. Software configures it in a config state: divider, word length (8 or 16 bits), clock polarity, clock phase and bit order. It then switches it to an active state and writes words into a four-entry transmit queue. Every word sent produces exactly one received word. The received word lands in a four-entry receive queue that software drains through the same data port.

A receive-level status flag rises once the receive queue holds at least a programmed number of words. When its enable bit is set, that flag drives a level-sensitive interrupt line. Status also reports both queue fill counts, an idle indication and a sticky flag for dropped transmit writes. A one-shot clear command empties both queues. A stop request holds back new words without disturbing the queued data. Chip select is driven outside this block.

Register offsets: 0x00 mode, 0x04 framing/interrupt control, 0x08 divider/length, 0x14 status, 0x18 data port.

Top module: `spi_host`

## Requirements
- R1: After reset the mode register reads 0x40 (config state, field [7:6]=01), the divider/length register reads 0x0108, status reads 0x0004 (idle bit 2 set, all counts zero), and irq and sclk are 0.
- R2: A data-port write made while mode field [7:6] is not 10 (active) is ignored: the transmit count in status bits [13:11] stays 0.
- R3: The divider/length register (divider n in [15:8], length in [4:0]) is writable only in config state. Within a word, sclk has a period of n+1 clock cycles, and a programmed n of 0 acts as 1.
- R4: Each transmitted word yields exactly one received word, popped in order by reading the data port. With miso tied to mosi, each popped word equals the sent word.
- R5: Framing bit 2 set sends the MSB first; clear sends the LSB first.
- R6: Framing bit 0 sets the idle level of sclk, and bit 1 selects whether data is sampled on the leading edge (0) or the trailing edge (1). Transfers are correct in every combination.
- R7: Status bit 14 is set while the receive count is at least framing field [13:12] plus one. irq equals status bit 14 AND framing bit 9.
- R8: Status bits [13:11] give the transmit fill count, bits [10:8] give the receive fill count, and bit 2 is set only when the transmit queue is empty and no word is shifting.
- R9: A data-port write while the transmit queue holds 4 words is dropped and sets sticky status bit 7. Writing mode bit 0 as 1 empties both queues and clears bit 7.
- R10: While mode bit 1 (stop request) is set, no new word starts shifting.
- R11: In 8-bit length (length field not 16) only the low 8 bits of a written word are sent, and data-port reads return zero in bits above 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (pops on data port) |
| busAddr | input | 5 | Register byte offset |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid in the strobe cycle |
| irq | output | 1 | Level receive-threshold interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A corrupted shift register or bit counter shows at the ports within one word time. The popped word differs from the sent one under loopback, or the number of sclk edges per word is wrong. A wrong queue pointer or count shows on the next status read as a wrong fill field, or in the next pop as an out-of-order word. A bad threshold compare moves irq one word early or late. The bench therefore checks status and irq after every individual word of a threshold sequence, not only at the end.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 5;

  localparam logic [1:0] MODE_CFG = 2'b01;
  localparam logic [1:0] MODE_ACT = 2'b10;

  localparam logic [ADDR_W-1:0] OFS_MODE = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_FRM  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_DIV  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_DATA = 5'h18;

  // strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic fifoClr;
  } dpStrobe_t;

  // static settings seen by the datapath
  typedef struct packed {
    logic       run;
    logic       cpol;
    logic       cpha;
    logic       msbFirst;
    logic       wide;
    logic [7:0] div;
  } dpCfg_t;
endpackage

// File: rtl/spi_host_fifo.sv
module spi_host_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [CNT_W-1:0] count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wrPtr] <= pushData;
  end

  assign headData = mem[rdPtr];

  // R9
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (count < CNT_W'(DEPTH)));
  // R4
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (count != '0));
endmodule

// File: rtl/spi_host_dp.sv
module spi_host_dp
  import spi_host_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  dpCfg_t            cfg,
  input  logic [WORD_W-1:0] txWord,
  output logic [WORD_W-1:0] rxWord,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  logic [WORD_W-1:0] txHead, txShift, rxShift, rxNext, rxPushData;
  logic [7:0] tick, nEff, half;
  logic [3:0] bitIdx, lastBit;
  logic startWord, lead, trail, sampleNow, curBit, mosiHeld, rxPush;

  assign nEff    = (cfg.div == 8'd0) ? 8'd1 : cfg.div;
  assign half    = 8'((9'(nEff) + 9'd1) >> 1);
  assign lastBit = cfg.wide ? 4'd15 : 4'd7;

  assign startWord = !busy && cfg.run && (txCount != '0);
  assign lead      = busy && (tick == half - 8'd1);
  assign trail     = busy && (tick == nEff);
  assign sampleNow = cfg.cpha ? trail : lead;
  assign curBit    = cfg.msbFirst ? txShift[lastBit] : txShift[0];

  always_comb begin
    if (cfg.msbFirst)  rxNext = {rxShift[WORD_W-2:0], miso};
    else if (cfg.wide) rxNext = {miso, rxShift[WORD_W-1:1]};
    else               rxNext = {8'h00, miso, rxShift[7:1]};
    rxPushData = sampleNow ? rxNext : rxShift;
    if (!cfg.wide) rxPushData[WORD_W-1:8] = '0;
  end

  assign rxPush = trail && (bitIdx == lastBit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      tick     <= '0;
      bitIdx   <= '0;
      txShift  <= '0;
      rxShift  <= '0;
      mosiHeld <= 1'b0;
    end else if (startWord) begin
      busy    <= 1'b1;
      tick    <= '0;
      bitIdx  <= '0;
      txShift <= cfg.wide ? txHead : {8'h00, txHead[7:0]};
      rxShift <= '0;
    end else if (busy) begin
      if (sampleNow) rxShift <= rxNext;
      if (lead && cfg.cpha) mosiHeld <= curBit;
      if (trail) begin
        tick    <= '0;
        bitIdx  <= bitIdx + 4'd1;
        txShift <= cfg.msbFirst ? (txShift << 1) : (txShift >> 1);
        if (bitIdx == lastBit) busy <= 1'b0;
      end else begin
        tick <= tick + 8'd1;
      end
    end
  end

  assign sclk = cfg.cpol ^ (busy && (tick >= half));
  assign mosi = cfg.cpha ? mosiHeld : curBit;

  spi_host_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) txFifo (
    .clk(clk), .rstN(rstN), .clr(stb.fifoClr),
    .push(stb.txPush), .pushData(txWord), .pop(startWord),
    .headData(txHead), .count(txCount)
  );

  spi_host_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) rxFifo (
    .clk(clk), .rstN(rstN), .clr(stb.fifoClr),
    .push(rxPush), .pushData(rxPushData), .pop(stb.rxPop),
    .headData(rxWord), .count(rxCount)
  );

  // R10
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.run && !busy) |=> !busy);
endmodule

// File: rtl/spi_host_ctl.sv
module spi_host_ctl
  import spi_host_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              irq,
  output dpStrobe_t         stb,
  output dpCfg_t            cfg,
  output logic [WORD_W-1:0] txWord,
  input  logic [WORD_W-1:0] rxWord,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic              busy
);
  logic [1:0] modeQ, rxLvlM1;
  logic       stopQ, rxIe, msbFirst, cpha, cpol, ovfQ;
  logic [7:0] divQ;
  logic [4:0] lenQ;
  logic       isActive, txFull, rxThr, idle, dataWr;
  logic       unusedWrBits;

  assign unusedWrBits = ^busWrData;
  assign isActive = (modeQ == MODE_ACT);
  assign txFull   = (txCount == CNT_W'(DEPTH));
  assign rxThr    = (rxCount >= (CNT_W'(rxLvlM1) + CNT_W'(1)));
  assign idle     = (txCount == '0) && !busy;
  assign dataWr   = busWrEn && (busAddr == OFS_DATA) && isActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= MODE_CFG;
      stopQ    <= 1'b0;
      rxLvlM1  <= '0;
      rxIe     <= 1'b0;
      msbFirst <= 1'b0;
      cpha     <= 1'b0;
      cpol     <= 1'b0;
      divQ     <= 8'd1;
      lenQ     <= 5'd8;
      ovfQ     <= 1'b0;
    end else begin
      if (busWrEn && busAddr == OFS_MODE) begin
        if (busWrData[7:6] == MODE_CFG || busWrData[7:6] == MODE_ACT)
          modeQ <= busWrData[7:6];
        stopQ <= busWrData[1];
      end
      if (busWrEn && busAddr == OFS_FRM) begin
        rxLvlM1  <= busWrData[13:12];
        rxIe     <= busWrData[9];
        msbFirst <= busWrData[2];
        cpha     <= busWrData[1];
        cpol     <= busWrData[0];
      end
      if (busWrEn && busAddr == OFS_DIV && modeQ == MODE_CFG) begin
        divQ <= busWrData[15:8];
        lenQ <= busWrData[4:0];
      end
      if (stb.fifoClr)          ovfQ <= 1'b0;
      else if (dataWr && txFull) ovfQ <= 1'b1;
    end
  end

  always_comb begin
    stb.fifoClr = busWrEn && (busAddr == OFS_MODE) && busWrData[0];
    stb.txPush  = dataWr && !txFull;
    stb.rxPop   = busRdEn && (busAddr == OFS_DATA) && (rxCount != '0);
    cfg.run      = isActive && !stopQ;
    cfg.cpol     = cpol;
    cfg.cpha     = cpha;
    cfg.msbFirst = msbFirst;
    cfg.wide     = (lenQ == 5'd16);
    cfg.div      = divQ;
  end

  assign txWord = busWrData[WORD_W-1:0];
  assign irq    = rxThr && rxIe;

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      OFS_MODE: busRdData = {24'h0, modeQ, 4'h0, stopQ, 1'b0};
      OFS_FRM:  busRdData = {16'h0, 2'b00, rxLvlM1, 2'b00, rxIe, 6'h00,
                             msbFirst, cpha, cpol};
      OFS_DIV:  busRdData = {16'h0, divQ, 3'b000, lenQ};
      OFS_STAT: busRdData = {16'h0, 1'b0, rxThr, 3'(txCount), 3'(rxCount),
                             ovfQ, 4'h0, idle, 2'b00};
      OFS_DATA: if (rxCount != '0)
                  busRdData = cfg.wide ? {16'h0, rxWord} : {24'h0, rxWord[7:0]};
      default:  busRdData = '0;
    endcase
  end

  // R3
  div_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    isActive |=> ($stable(divQ) && $stable(lenQ)));
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfQ && !stb.fifoClr) |=> ovfQ);
  // R2
  cfg_no_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != MODE_ACT) |-> !stb.txPush);
endmodule

// File: rtl/spi_host.sv
module spi_host
  import spi_host_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  dpStrobe_t         stb;
  dpCfg_t            cfg;
  logic [WORD_W-1:0] txWord, rxWord;
  logic [CNT_W-1:0]  txCount, rxCount;
  logic              busy;

  spi_host_ctl #(.DEPTH(DEPTH)) ctl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irq(irq), .stb(stb), .cfg(cfg), .txWord(txWord), .rxWord(rxWord),
    .txCount(txCount), .rxCount(rxCount), .busy(busy)
  );

  spi_host_dp #(.DEPTH(DEPTH)) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfg(cfg), .txWord(txWord),
    .rxWord(rxWord), .txCount(txCount), .rxCount(rxCount), .busy(busy),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );
endmodule

// File: tb/tb_spi_host.sv
`timescale 1ns/100ps
module tb_spi_host;
  localparam logic [4:0] A_MODE = 5'h00, A_FRM = 5'h04, A_DIV = 5'h08,
                         A_STAT = 5'h14, A_DATA = 5'h18;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN, busWrEn, busRdEn, irq, sclk, mosi, miso;
  logic [4:0]  busAddr;
  logic [31:0] busWrData, busRdData;

  assign miso = mosi;

  spi_host dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  int nRun = 0, nFail = 0;
  bit finished = 0;
  logic [15:0] expQ[$];

  bit      capOn = 0;
  int      edgeN = 0;
  realtime edgeT[32];
  logic    edgeBit[32];

  always @(posedge sclk) begin
    if (capOn && edgeN < 32) begin
      edgeT[edgeN] = $realtime;
      edgeBit[edgeN] = mosi;
      edgeN = edgeN + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1; busAddr = a;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 0;
  endtask

  // driver: push expected result, then feed the data port
  task automatic sendWord(input logic [15:0] d, input bit wide);
    expQ.push_back(wide ? d : {8'h00, d[7:0]});
    wr(A_DATA, {16'h0, d});
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(A_STAT, s);
      if (s[2]) return;
    end
    chk("R8", "idle timeout", 32'h0, 32'h4);
  endtask

  // monitor: pop results and compare with the scoreboard queue
  task automatic collect(input int n, input string req);
    logic [31:0] d;
    for (int i = 0; i < n; i++) begin
      rd(A_DATA, d);
      if (expQ.size() == 0) chk(req, "unexpected word", d, 32'hx);
      else chk(req, "rx word", d, {16'h0, expQ.pop_front()});
    end
  endtask

  function automatic logic [15:0] edgeWord();
    logic [15:0] v = '0;
    for (int i = 0; i < edgeN; i++) v = {v[14:0], edgeBit[i]};
    return v;
  endfunction

  initial begin
    #100000;
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rstN = 0; busWrEn = 0; busRdEn = 0; busAddr = '0; busWrData = '0;
    repeat (4) @(negedge clk);
    rstN = 1;

    // R1 reset state
    rd(A_MODE, d); chk("R1", "mode reset", d, 32'h40);
    rd(A_DIV, d);  chk("R1", "div reset", d, 32'h0108);
    rd(A_STAT, d); chk("R1", "status reset", d, 32'h0004);
    chk("R1", "irq/sclk reset", {30'h0, irq, sclk}, 32'h0);

    // R2 data write in config ignored
    wr(A_DATA, 32'h55);
    rd(A_STAT, d); chk("R2", "tx count in config", d, 32'h0004);

    // R3/R5/R11 8-bit MSB first, divider 3
    wr(A_DIV, 32'h0308);
    wr(A_FRM, 32'h4);
    wr(A_MODE, 32'h80);
    wr(A_DIV, 32'h0510);
    rd(A_DIV, d); chk("R3", "div write in active ignored", d, 32'h0308);
    edgeN = 0; capOn = 1;
    sendWord(16'h3CA1, 0);
    waitIdle(); capOn = 0;
    chk("R3", "edges per 8-bit word", edgeN, 8);
    chk("R3", "period n=3 (x100ps)", int'((edgeT[1] - edgeT[0]) * 10.0), 200);
    chk("R5", "msb-first order", edgeWord(), 16'h00A1);
    collect(1, "R11");

    // R5 LSB first
    wr(A_FRM, 32'h0);
    edgeN = 0; capOn = 1;
    sendWord(16'h00A1, 0);
    waitIdle(); capOn = 0;
    chk("R5", "lsb-first order", edgeWord(), 16'h0085);
    collect(1, "R4");

    // R3 divider clamp, 16-bit
    wr(A_MODE, 32'h40);
    wr(A_DIV, 32'h0010);
    wr(A_FRM, 32'h4);
    wr(A_MODE, 32'h80);
    edgeN = 0; capOn = 1;
    sendWord(16'hBEEF, 1);
    waitIdle(); capOn = 0;
    chk("R3", "edges per 16-bit word", edgeN, 16);
    chk("R3", "period n=0 clamps to 1", int'((edgeT[1] - edgeT[0]) * 10.0), 100);
    collect(1, "R4");

    // R4/R8 four back-to-back words
    sendWord(16'h1234, 1); sendWord(16'h8001, 1);
    sendWord(16'hFFFF, 1); sendWord(16'h0F0F, 1);
    waitIdle();
    rd(A_STAT, d); chk("R8", "rx count field", {29'h0, d[10:8]}, 32'd4);
    collect(4, "R4");

    // R6 polarity/phase combinations
    wr(A_FRM, 32'h7);
    repeat (2) @(negedge clk);
    chk("R6", "idle sclk with cpol=1", {31'h0, sclk}, 32'h1);
    sendWord(16'h5A3C, 1); waitIdle(); collect(1, "R6");
    wr(A_FRM, 32'h6);
    sendWord(16'hC001, 1); waitIdle(); collect(1, "R6");
    wr(A_FRM, 32'h1);
    sendWord(16'h0F0E, 1); waitIdle(); collect(1, "R6");

    // R7 threshold 2 with interrupt enabled
    wr(A_FRM, 32'h1204);
    sendWord(16'h1111, 1); waitIdle();
    rd(A_STAT, d); chk("R7", "thr after 1 word", {31'h0, d[14]}, 32'h0);
    chk("R7", "irq after 1 word", {31'h0, irq}, 32'h0);
    sendWord(16'h2222, 1); waitIdle();
    rd(A_STAT, d); chk("R7", "thr after 2 words", {31'h0, d[14]}, 32'h1);
    chk("R7", "irq after 2 words", {31'h0, irq}, 32'h1);
    wr(A_FRM, 32'h1004);
    rd(A_STAT, d); chk("R7", "thr with irq disabled", {31'h0, d[14]}, 32'h1);
    chk("R7", "irq masked", {31'h0, irq}, 32'h0);
    collect(2, "R4");
    rd(A_STAT, d); chk("R7", "thr after drain", {31'h0, d[14]}, 32'h0);

    // R10/R9 stop request, overflow, clear
    wr(A_MODE, 32'h82);
    for (int i = 0; i < 4; i++) wr(A_DATA, 32'h40 + i);
    repeat (40) @(negedge clk);
    rd(A_STAT, d);
    chk("R10", "stopped: tx=4 rx=0 not idle", {16'h0, d[15:0]}, 32'h2000);
    wr(A_DATA, 32'h99);
    rd(A_STAT, d);
    chk("R9", "overflow flag, tx stays 4", {16'h0, d[15:0]}, 32'h2080);
    wr(A_MODE, 32'h83);
    rd(A_STAT, d); chk("R9", "clear empties and drops flag", d, 32'h0004);
    wr(A_MODE, 32'h80);
    repeat (40) @(negedge clk);
    rd(A_STAT, d); chk("R8", "nothing sent after clear", d, 32'h0004);

    chk("R4", "scoreboard empty", expQ.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule